// File: doc/BRIEF.md
# Disk controller register interface

This block is the host-facing register file of a four-drive cartridge disk controller. A host reaches five 16-bit registers through a small register bus: control/status, bus address, disk address, a multipurpose register and a bus address extension. It can write whole words or single bytes. The block holds the state these registers expose and decides when a command starts. A command starts when the host writes control/status with the done bit clear. The block reports the start to an external command engine through a one-cycle strobe, together with the function code and the drive number.

The engine reports the end of a command with a completion strobe and a set of error flags. It may also fill the multipurpose queue with result words. The multipurpose register is a three-entry queue. A host write fills every entry, and each host read takes the front entry and moves the others one place toward the front. The block also keeps the error summary and the interrupt request, and it mirrors the two low address-extension bits into control/status.

Top module: `dkc_regs`

## Requirements
- R1: The register is selected by `reg_addr[3:1]`: 0 control/status, 1 bus address, 2 disk address, 3 multipurpose, 4 address extension. Selects 5 to 7 read as zero, and writes to them change no register.
- R2: Control/status reads as follows. Bit 0 is ready, which is the inverse of `drive_busy` for the drive in bits 9:8. Bits 3:1 are the function, bits 5:4 are the extension bits 1:0, bit 6 is the interrupt enable, bit 7 is done and bits 9:8 are the drive. Bits 14:10 are the stored error flags, and bit 15 is the OR of bits 14:10.
- R3: A control/status write changes only bits 9:1. Bits 0 and 15:10 cannot be written.
- R4: When `byte_wr` is 1, the byte comes from `wr_data[7:0]`. It replaces bits 15:8 when `reg_addr[0]` is 1 and bits 7:0 when it is 0, and the other byte keeps its current read value. When `byte_wr` is 0, the whole word is written.
- R5: A control/status write whose resulting bit 7 is 1 starts nothing, and it sets `irq` equal to the written bit 6.
- R6: A control/status write whose resulting bit 7 is 0 clears `irq` and error bits 14:10. If the function is not zero, `cmd_start` is 1 in the following cycle, done stays 0, and `cmd_func` and `cmd_drive` carry the written fields. Function 0 starts nothing: done returns to 1 and `irq` becomes bit 6.
- R7: A host write to the multipurpose register loads the merged value into all three entries. A read returns entry 0 and then shifts entry 1 into 0 and entry 2 into 1, with entry 2 kept. If a host write and a read fall in the same cycle, the write wins.
- R8: Bit 0 of the bus address always reads 0. The extension register holds 6 bits, and its bits 1:0 and control/status bits 5:4 are one value that either register can write. Extension writes with `reg_addr[0]`=1 are ignored.
- R9: After reset, control/status holds only done (reading 0x0081 with the drive idle), all other registers and queue entries are 0, and `irq` and `cmd_start` are 0.
- R10: `cmd_done` sets done, ORs `cmd_err` into bits 14:10 and sets `irq` to the interrupt enable.
- R11: `mp_fill` loads entry i from `mp_fill_data[16*i+15:16*i]`. A host multipurpose write wins over a fill, and a fill wins over a read shift.
- R12: When `cmd_done` and a control/status write fall in the same cycle, a starting write wins: errors are cleared and done reads 0. A write with done=1 keeps the completion's errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the multipurpose queue) |
| reg_addr | input | 4 | Bits 3:1 select the register, bit 0 selects the byte lane |
| byte_wr | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| drive_busy | input | 4 | Busy flag of each drive |
| cmd_done | input | 1 | Completion strobe from the engine |
| cmd_err | input | 5 | Error flags for control/status bits 14:10 |
| mp_fill | input | 1 | Engine load of the multipurpose queue |
| mp_fill_data | input | 48 | Queue contents, with entry i in slice i |
| cmd_start | output | 1 | One-cycle command start strobe |
| cmd_func | output | 3 | Function code of the command |
| cmd_drive | output | 2 | Drive number of the command |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. A control/status write can meet the engine's completion strobe, and a multipurpose read can meet a host write or an engine fill. Directed steps place a starting write and a done=1 write on the completion cycle and a read on a fill cycle. The random phase then drives all four strobes independently, so these overlaps recur many times. Each outcome is judged against a bench model that applies R12 and R7/R11 priority, by comparing read data, `irq` and the start strobe in the cycle after the edge.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
    localparam int REG_W   = 16;
    localparam int FUNC_W  = 3;
    localparam int ERR_W   = 5;
    localparam int DRVF_W  = 2;

    // control/status bit positions
    localparam int RDY_BIT  = 0;
    localparam int FUNC_LO  = 1;
    localparam int MEX_LO   = 4;
    localparam int IE_BIT   = 6;
    localparam int DONE_BIT = 7;
    localparam int DRV_LO   = 8;
    localparam int ERR_LO   = 10;
    localparam int SUM_BIT  = 15;

    localparam logic [REG_W-1:0] BA_KEEP = 16'hFFFE;

    typedef enum logic [2:0] {
        SEL_CSR = 3'd0,
        SEL_BA  = 3'd1,
        SEL_DA  = 3'd2,
        SEL_MP  = 3'd3,
        SEL_EXT = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/dkc_lane_merge.sv
module dkc_lane_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] old_word,
    input  logic [W-1:0] new_data,
    input  logic         byte_mode,
    input  logic         hi_lane,
    output logic [W-1:0] merged
);
    localparam int HALF = W / 2;

    always_comb begin
        if (!byte_mode)
            merged = new_data;
        else if (hi_lane)
            merged = {new_data[HALF-1:0], old_word[HALF-1:0]};
        else
            merged = {old_word[W-1:HALF], new_data[HALF-1:0]};
    end
endmodule

// File: rtl/dkc_mp_queue.sv
module dkc_mp_queue #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_load,
    input  logic [W-1:0]       host_val,
    input  logic               fill,
    input  logic [DEPTH*W-1:0] fill_vec,
    input  logic               pop,
    output logic [W-1:0]       head
);
    typedef logic [DEPTH-1:0][W-1:0] ents_t;

    ents_t ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        if (host_load) begin
            for (int i = 0; i < DEPTH; i++) ents_d[i] = host_val;
        end else if (fill) begin
            for (int i = 0; i < DEPTH; i++) ents_d[i] = fill_vec[i*W +: W];
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) ents_d[i] = ents_q[i+1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ents_q <= '0;
        else        ents_q <= ents_d;
    end

    assign head = ents_q[0];

    // R7
    mp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_load |=> head == $past(host_val));

    // R7
    mp_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !host_load && !fill) |=> head == $past(ents_q[1]));

    // R11
    mp_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !host_load) |=> head == $past(fill_vec[W-1:0]));
endmodule

// File: rtl/dkc_csr.sv
module dkc_csr import dkc_pkg::*; #(
    parameter int N_DRIVES = 4,
    parameter int EXT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_wr,
    input  logic                ext_wr,
    input  logic [REG_W-1:0]    wr_word,
    input  logic [N_DRIVES-1:0] drive_busy,
    input  logic                cmd_done,
    input  logic [ERR_W-1:0]    cmd_err,
    output logic [REG_W-1:0]    csr_rd,
    output logic [EXT_W-1:0]    ext_rd,
    output logic                irq,
    output logic                cmd_start,
    output logic [FUNC_W-1:0]   cmd_func,
    output logic [DRVF_W-1:0]   cmd_drive
);
    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic              ie;
        logic              done;
        logic [DRVF_W-1:0] drive;
        logic [ERR_W-1:0]  errs;
        logic [EXT_W-1:0]  ext;
        logic              irq;
        logic              start;
    } csr_t;

    csr_t q, d;
    logic sel_busy;

    // busy flag of the addressed drive
    always_comb begin
        sel_busy = 1'b1;
        for (int i = 0; i < N_DRIVES; i++)
            if (q.drive == DRVF_W'(i)) sel_busy = drive_busy[i];
    end

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (cmd_done) begin
            d.done = 1'b1;
            d.errs = q.errs | cmd_err;
            d.irq  = q.ie;
        end
        if (ext_wr)
            d.ext = wr_word[EXT_W-1:0];
        if (csr_wr) begin
            d.func      = wr_word[FUNC_LO +: FUNC_W];
            d.ext[1:0]  = wr_word[MEX_LO +: 2];
            d.ie        = wr_word[IE_BIT];
            d.done      = wr_word[DONE_BIT];
            d.drive     = wr_word[DRV_LO +: DRVF_W];
            if (wr_word[DONE_BIT]) begin
                d.irq = wr_word[IE_BIT];
            end else begin
                d.irq  = 1'b0;
                d.errs = '0;
                if (wr_word[FUNC_LO +: FUNC_W] == '0) begin
                    d.done = 1'b1;
                    d.irq  = wr_word[IE_BIT];
                end else begin
                    d.start = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.done <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        csr_rd                      = '0;
        csr_rd[RDY_BIT]             = ~sel_busy;
        csr_rd[FUNC_LO +: FUNC_W]   = q.func;
        csr_rd[MEX_LO +: 2]         = q.ext[1:0];
        csr_rd[IE_BIT]              = q.ie;
        csr_rd[DONE_BIT]            = q.done;
        csr_rd[DRV_LO +: DRVF_W]    = q.drive;
        csr_rd[ERR_LO +: ERR_W]     = q.errs;
        csr_rd[SUM_BIT]             = |q.errs;
    end

    assign ext_rd    = q.ext;
    assign irq       = q.irq;
    assign cmd_start = q.start;
    assign cmd_func  = q.func;
    assign cmd_drive = q.drive;

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> !q.done);

    // R10
    done_after_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !csr_wr) |=> q.done);

    // R5
    irq_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> (q.ie && q.done));
endmodule

// File: rtl/dkc_regs.sv
module dkc_regs import dkc_pkg::*; #(
    parameter int N_DRIVES = 4,
    parameter int MP_DEPTH = 3,
    parameter int EXT_W    = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [3:0]                reg_addr,
    input  logic                      byte_wr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [REG_W-1:0]          rd_data,
    input  logic [N_DRIVES-1:0]       drive_busy,
    input  logic                      cmd_done,
    input  logic [ERR_W-1:0]          cmd_err,
    input  logic                      mp_fill,
    input  logic [MP_DEPTH*REG_W-1:0] mp_fill_data,
    output logic                      cmd_start,
    output logic [FUNC_W-1:0]         cmd_func,
    output logic [DRVF_W-1:0]         cmd_drive,
    output logic                      irq
);
    typedef struct packed {
        logic [REG_W-1:0] ba;
        logic [REG_W-1:0] da;
    } addr_regs_t;

    addr_regs_t ar_d, ar_q;
    reg_sel_e   sel;
    logic       hi_lane;
    logic [REG_W-1:0] cur_word, merged, csr_rd, mp_head;
    logic [EXT_W-1:0] ext_rd;
    logic csr_wr, ext_wr, mp_wr, mp_pop;

    assign sel     = reg_sel_e'(reg_addr[3:1]);
    assign hi_lane = reg_addr[0];

    always_comb begin
        case (sel)
            SEL_CSR: cur_word = csr_rd;
            SEL_BA:  cur_word = ar_q.ba;
            SEL_DA:  cur_word = ar_q.da;
            SEL_MP:  cur_word = mp_head;
            SEL_EXT: cur_word = REG_W'(ext_rd);
            default: cur_word = '0;
        endcase
    end
    assign rd_data = cur_word;

    dkc_lane_merge #(.W(REG_W)) u_merge (
        .old_word (cur_word),
        .new_data (wr_data),
        .byte_mode(byte_wr),
        .hi_lane  (hi_lane),
        .merged   (merged)
    );

    assign csr_wr = reg_wr && (sel == SEL_CSR);
    assign ext_wr = reg_wr && (sel == SEL_EXT) && !hi_lane;
    assign mp_wr  = reg_wr && (sel == SEL_MP);
    assign mp_pop = reg_rd && (sel == SEL_MP);

    always_comb begin
        ar_d = ar_q;
        if (reg_wr && sel == SEL_BA) ar_d.ba = merged & BA_KEEP;
        if (reg_wr && sel == SEL_DA) ar_d.da = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ar_q <= '0;
        else        ar_q <= ar_d;
    end

    dkc_csr #(.N_DRIVES(N_DRIVES), .EXT_W(EXT_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .ext_wr    (ext_wr),
        .wr_word   (merged),
        .drive_busy(drive_busy),
        .cmd_done  (cmd_done),
        .cmd_err   (cmd_err),
        .csr_rd    (csr_rd),
        .ext_rd    (ext_rd),
        .irq       (irq),
        .cmd_start (cmd_start),
        .cmd_func  (cmd_func),
        .cmd_drive (cmd_drive)
    );

    dkc_mp_queue #(.W(REG_W), .DEPTH(MP_DEPTH)) u_mpq (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_load(mp_wr),
        .host_val (merged),
        .fill     (mp_fill),
        .fill_vec (mp_fill_data),
        .pop      (mp_pop),
        .head     (mp_head)
    );

    // R8
    ba_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_BA) |=> (rd_data[0] == 1'b0 || sel != SEL_BA));
endmodule

// File: tb/dkc_regs_bench.sv
module dkc_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0, byte_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic [3:0]  drive_busy = 0;
    logic        cmd_done = 0;
    logic [4:0]  cmd_err = 0;
    logic        mp_fill = 0;
    logic [47:0] mp_fill_data = 0;
    logic        cmd_start, irq;
    logic [2:0]  cmd_func;
    logic [1:0]  cmd_drive;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    dkc_regs u_dkc_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .byte_wr(byte_wr), .wr_data(wr_data),
        .rd_data(rd_data), .drive_busy(drive_busy), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .mp_fill(mp_fill), .mp_fill_data(mp_fill_data),
        .cmd_start(cmd_start), .cmd_func(cmd_func), .cmd_drive(cmd_drive),
        .irq(irq)
    );

    // model state
    logic [2:0]  m_func;
    logic        m_ie, m_done, m_irq, m_start;
    logic [1:0]  m_drive;
    logic [4:0]  m_errs;
    logic [5:0]  m_ext;
    logic [15:0] m_ba, m_da;
    logic [15:0] m_mp [3];

    task automatic model_reset();
        m_func = 0; m_ie = 0; m_done = 1; m_irq = 0; m_start = 0;
        m_drive = 0; m_errs = 0; m_ext = 0; m_ba = 0; m_da = 0;
        for (int i = 0; i < 3; i++) m_mp[i] = 0;
    endtask

    function automatic logic [15:0] exp_rd(input logic [2:0] sel, input logic [3:0] bz);
        case (sel)
            3'd0: exp_rd = {|m_errs, m_errs, m_drive, m_done, m_ie, m_ext[1:0], m_func, ~bz[m_drive]};
            3'd1: exp_rd = m_ba;
            3'd2: exp_rd = m_da;
            3'd3: exp_rd = m_mp[0];
            3'd4: exp_rd = {10'd0, m_ext};
            default: exp_rd = 16'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] sel);
        case (sel)
            3'd0: rd_tag = "R2";
            3'd3: rd_tag = "R7";
            3'd1, 3'd4: rd_tag = "R8";
            default: rd_tag = "R1";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_step(input logic wr, input logic rd, input logic [2:0] sel,
                              input logic byt, input logic hi, input logic [15:0] wd,
                              input logic dn, input logic [4:0] er, input logic fl,
                              input logic [47:0] fd, input logic [3:0] bz);
        logic [15:0] old, mg;
        logic [15:0] n_mp [3];
        old = exp_rd(sel, bz);
        mg  = !byt ? wd : (hi ? {wd[7:0], old[7:0]} : {old[15:8], wd[7:0]});
        for (int i = 0; i < 3; i++) n_mp[i] = m_mp[i];
        m_start = 0;
        if (dn) begin
            m_done = 1; m_errs = m_errs | er; m_irq = m_ie;
        end
        if (wr) begin
            case (sel)
                3'd0: begin
                    m_func = mg[3:1]; m_ext[1:0] = mg[5:4]; m_ie = mg[6];
                    m_done = mg[7]; m_drive = mg[9:8];
                    if (mg[7]) m_irq = mg[6];
                    else begin
                        m_irq = 0; m_errs = 0;
                        if (mg[3:1] == 3'd0) begin m_done = 1; m_irq = mg[6]; end
                        else m_start = 1;
                    end
                end
                3'd1: m_ba = mg & 16'hFFFE;
                3'd2: m_da = mg;
                3'd3: for (int i = 0; i < 3; i++) n_mp[i] = mg;
                3'd4: if (!hi) m_ext = mg[5:0];
                default: ;
            endcase
        end
        if (!(wr && sel == 3'd3)) begin
            if (fl) begin
                for (int i = 0; i < 3; i++) n_mp[i] = fd[16*i +: 16];
            end else if (rd && sel == 3'd3) begin
                n_mp[0] = m_mp[1]; n_mp[1] = m_mp[2];
            end
        end
        for (int i = 0; i < 3; i++) m_mp[i] = n_mp[i];
    endtask

    task automatic step(input string tag, input logic wr, input logic rd, input logic [2:0] sel,
                        input logic byt, input logic hi, input logic [15:0] wd,
                        input logic dn, input logic [4:0] er, input logic fl,
                        input logic [47:0] fd, input logic [3:0] bz);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = {sel, hi}; byte_wr = byt; wr_data = wd;
        cmd_done = dn; cmd_err = er; mp_fill = fl; mp_fill_data = fd; drive_busy = bz;
        #1;
        check({tag, "/", rd_tag(sel)}, "read data", rd_data, exp_rd(sel, bz));
        model_step(wr, rd, sel, byt, hi, wd, dn, er, fl, fd, bz);
        @(posedge clk);
        #2;
        reg_wr = 0; reg_rd = 0; cmd_done = 0; mp_fill = 0;
        check({tag, "/R10"}, "irq", {15'd0, irq}, {15'd0, m_irq});
        check({tag, "/R6"}, "start", {15'd0, cmd_start}, {15'd0, m_start});
        if (m_start) begin
            check({tag, "/R6"}, "func", {13'd0, cmd_func}, {13'd0, m_func});
            check({tag, "/R6"}, "drive", {14'd0, cmd_drive}, {14'd0, m_drive});
        end
    endtask

    task automatic wr_reg(input string tag, input logic [2:0] sel, input logic byt,
                          input logic hi, input logic [15:0] wd);
        step(tag, 1, 0, sel, byt, hi, wd, 0, 0, 0, 0, 0);
    endtask

    task automatic rd_reg(input string tag, input logic [2:0] sel);
        step(tag, 0, 1, sel, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset values, R1 decode of every select
        for (int s = 0; s < 8; s++) rd_reg("R9", 3'(s));
        check("R9", "csr after reset", exp_rd(0, 0), 16'h0081);

        // R3 write mask, R5 done=1 write raises irq from ie
        wr_reg("R3", 3'd0, 0, 0, 16'hFFFF);
        rd_reg("R3", 3'd0);
        check("R3", "csr model", exp_rd(0, 0), 16'h03FF);
        wr_reg("R5", 3'd0, 0, 0, 16'h0080);

        // R8 extension mirror and odd-write ignore, BA bit 0
        wr_reg("R8", 3'd4, 0, 0, 16'h003F);
        rd_reg("R8", 3'd0);
        wr_reg("R8", 3'd4, 1, 1, 16'h0000);
        rd_reg("R8", 3'd4);
        wr_reg("R8", 3'd0, 0, 0, 16'h00A0);
        rd_reg("R8", 3'd4);
        wr_reg("R8", 3'd1, 0, 0, 16'hFFFF);
        rd_reg("R8", 3'd1);

        // R4 byte lanes
        wr_reg("R4", 3'd2, 0, 0, 16'h1234);
        wr_reg("R4", 3'd2, 1, 1, 16'h00AB);
        wr_reg("R4", 3'd2, 1, 0, 16'h00CD);
        rd_reg("R4", 3'd2);
        check("R4", "da model", m_da, 16'hABCD);

        // R6 start on drive 1 with busy drive, R10 completion with error
        step("R6", 1, 0, 3'd0, 0, 0, 16'h0144, 0, 0, 0, 0, 4'b0010);
        step("R6", 0, 1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 4'b0010);
        step("R10", 0, 1, 3'd0, 0, 0, 0, 1, 5'b00100, 0, 0, 4'b0000);
        check("R10", "summary model", exp_rd(0, 0) & 16'h9080, 16'h9080);
        wr_reg("R6", 3'd0, 0, 0, 16'h0040);
        rd_reg("R6", 3'd0);

        // R7 queue, R11 fill
        wr_reg("R7", 3'd3, 0, 0, 16'h1111);
        step("R11", 0, 0, 3'd3, 0, 0, 0, 0, 0, 1, 48'h3333_2222_AAAA, 0);
        for (int k = 0; k < 4; k++) rd_reg("R7", 3'd3);
        step("R11", 0, 1, 3'd3, 0, 0, 0, 0, 0, 1, 48'h6666_5555_4444, 0);
        step("R7", 1, 1, 3'd3, 1, 1, 16'h0077, 0, 0, 0, 0, 0);
        rd_reg("R7", 3'd3);

        // R12 collisions
        wr_reg("R12", 3'd0, 0, 0, 16'h0046);
        step("R12", 1, 0, 3'd0, 0, 0, 16'h004A, 1, 5'b11111, 0, 0, 0);
        rd_reg("R12", 3'd0);
        step("R12", 1, 0, 3'd0, 0, 0, 16'h00C2, 1, 5'b01010, 0, 0, 0);
        rd_reg("R12", 3'd0);

        // R1 unused select writes
        wr_reg("R1", 3'd6, 0, 0, 16'hFFFF);
        for (int s = 0; s < 8; s++) rd_reg("R1", 3'(s));

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step("RND", r[0], r[1], r[4:2], r[5], r[6], $urandom,
                 (r[9:7] == 3'd0), r[14:10], (r[18:15] == 4'd0),
                 {$urandom, $urandom}, r[22:19]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule